// File: doc/BRIEF.md
# Four-Channel DMA Register Port

This block is the processor-side register file of a four-channel DMA controller that sits on a byte-wide I/O bus. Software writes and reads it one byte per access. Each channel has a 16-bit transfer address, a 16-bit transfer count, a page byte and an extended page byte. The count holds the number of transfer units minus one. The block also holds a 6-bit mode per channel, a mask bit per channel, a request bit per channel, a command byte and the terminal-count status flags.

The 16-bit address and count registers are each reached through a single byte port. One byte pointer, shared by every such port, chooses the low or the high byte and flips after each access. Software puts it back to the low byte with an explicit clear. The transfer engine is not part of this block. It reads the register values from the output ports and sends terminal-count pulses back in on `tc_i`.

A bus access lasts one cycle, with `wr_i` or `rd_i` high, never both. Read data is combinational while `rd_i` is high. Any side effect of a read takes effect at the clock edge that ends the access.

Port offsets on `addr_i`:

| Offset | Function |
|---|---|
| 0x00+ch | channel address |
| 0x04+ch | channel count |
| 0x08+ch | page |
| 0x0C+ch | extended page |
| 0x10 | command (write) / status (read) |
| 0x11 | request |
| 0x12 | single mask |
| 0x13 | mode |
| 0x14 | clear pointer |
| 0x15 | master clear |
| 0x16 | clear all masks |
| 0x17 | load all masks |

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1. The mode, status, request, command, address, count and page registers are all 0. The byte pointer selects the low byte.
- R2: An access to an address port (0x00+ch) or a count port (0x04+ch) reaches the low byte when the pointer is low and the high byte when it is high, and then flips the pointer. Reads and writes on all eight of these ports share the one pointer. The values appear on `ch_addr_o` and `ch_count_o`, 16 bits per channel, channel 0 in the lowest bits.
- R3: A write of any value to offset 0x14 makes the next address or count access reach the low byte.
- R4: A write to offset 0x12 picks the channel with data bits [1:0]. Data bit 2 = 1 sets that channel's mask bit and bit 2 = 0 clears it. The other mask bits do not change.
- R5: A write to offset 0x13 picks the channel with data bits [1:0] and stores data bits [7:2] as that channel's mode on `ch_mode_o`, 6 bits per channel. For example, 0x45 gives channel 1 the mode 0x11.
- R6: `tc_o[ch]` is set by a pulse on `tc_i[ch]`. A read of offset 0x10 returns the flags in bits [3:0] and the request bits in bits [7:4], and then clears the flags it returned. A pulse that arrives in the same cycle as the read leaves its flag set.
- R7: A write of any value to offset 0x15 sets all mask bits and clears the status flags, the modes, the request bits, the command byte and the byte pointer. The address, count and page registers keep their values.
- R8: A write to offset 0x16 clears all four mask bits.
- R9: A write to offset 0x17 loads the mask bits from data bits [3:0]. A read of offset 0x17 returns the mask in bits [3:0], with bits [7:4] = 0.
- R10: Offset 0x08+ch holds address bits [23:16] and offset 0x0C+ch holds bits [31:24]. Both can be read back. `ch_page_o` gives {extended page, page} as 16 bits per channel.
- R11: A write to offset 0x11 picks the channel with data bits [1:0]. Data bit 2 sets or clears that channel's request bit on `req_o`. A read of 0x11 returns the request bits in bits [3:0].
- R12: A write to offset 0x10 stores the whole byte on `cmd_o`.
- R13: Offsets 0x18 to 0x1F read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Port offset |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| tc_i | input | 4 | Terminal-count pulses, one bit per channel |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Software request bits |
| mask_o | output | 4 | Channel mask bits, 1 = disabled |
| tc_o | output | 4 | Terminal-count flags |
| ch_addr_o | output | 64 | Transfer address per channel |
| ch_count_o | output | 64 | Transfer count minus one, per channel |
| ch_page_o | output | 64 | {extended page, page} per channel |
| ch_mode_o | output | 24 | Mode per channel |

## Verification
The state that is hardest to reach from the ports is the hidden byte pointer, because no port shows it. The stimulus sets the pointer high by accessing one port and then accesses a different port. It also issues a master clear while the pointer is high and then reads back a byte whose two halves differ, so the low byte read proves the pointer was reset. A second difficult case is a terminal-count pulse that lands in the same cycle as a status read. The bench drives `tc_i` in the very cycle of the read, checks that the returned byte lacks the new flag, and checks that the flag is still set afterwards.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int MODE_W = BYTE_W - CH_W;
  localparam int OFS_W  = 5;

  // per-channel groups: base + channel
  localparam logic [OFS_W-1:0] OFS_ADDR    = 5'h00;
  localparam logic [OFS_W-1:0] OFS_CNT     = 5'h04;
  localparam logic [OFS_W-1:0] OFS_PAGE    = 5'h08;
  localparam logic [OFS_W-1:0] OFS_XPAGE   = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_CMD     = 5'h10;
  localparam logic [OFS_W-1:0] OFS_REQ     = 5'h11;
  localparam logic [OFS_W-1:0] OFS_SMASK   = 5'h12;
  localparam logic [OFS_W-1:0] OFS_MODE    = 5'h13;
  localparam logic [OFS_W-1:0] OFS_CLRPTR  = 5'h14;
  localparam logic [OFS_W-1:0] OFS_MCLR    = 5'h15;
  localparam logic [OFS_W-1:0] OFS_CLRMASK = 5'h16;
  localparam logic [OFS_W-1:0] OFS_WRMASK  = 5'h17;

  typedef struct packed {
    logic [NUM_CH-1:0] addr;
    logic [NUM_CH-1:0] cnt;
    logic [NUM_CH-1:0] page;
    logic [NUM_CH-1:0] xpage;
    logic cmd;
    logic req;
    logic smask;
    logic mode;
    logic clrptr;
    logic mclr;
    logic clrmask;
    logic wrmask;
  } port_hit_t;

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] cur,
                                                input logic hi,
                                                input logic [BYTE_W-1:0] b);
    return hi ? {b, cur[BYTE_W-1:0]} : {cur[REG_W-1:BYTE_W], b};
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(input logic [REG_W-1:0] cur,
                                                 input logic hi);
    return hi ? cur[REG_W-1:BYTE_W] : cur[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regfile_pkg::*;
(
  input  logic [OFS_W-1:0] addr_i,
  output port_hit_t        hit_o
);
  localparam int GRP_W = OFS_W - CH_W;

  logic [GRP_W-1:0] grp;
  logic [CH_W-1:0]  chn;
  assign grp = addr_i[OFS_W-1:CH_W];
  assign chn = addr_i[CH_W-1:0];

  always_comb begin
    hit_o = '0;
    if (grp == OFS_ADDR[OFS_W-1:CH_W])  hit_o.addr[chn]  = 1'b1;
    if (grp == OFS_CNT[OFS_W-1:CH_W])   hit_o.cnt[chn]   = 1'b1;
    if (grp == OFS_PAGE[OFS_W-1:CH_W])  hit_o.page[chn]  = 1'b1;
    if (grp == OFS_XPAGE[OFS_W-1:CH_W]) hit_o.xpage[chn] = 1'b1;
    hit_o.cmd     = (addr_i == OFS_CMD);
    hit_o.req     = (addr_i == OFS_REQ);
    hit_o.smask   = (addr_i == OFS_SMASK);
    hit_o.mode    = (addr_i == OFS_MODE);
    hit_o.clrptr  = (addr_i == OFS_CLRPTR);
    hit_o.mclr    = (addr_i == OFS_MCLR);
    hit_o.clrmask = (addr_i == OFS_CLRMASK);
    hit_o.wrmask  = (addr_i == OFS_WRMASK);
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_o <= 1'b0;
    else if (clr_i)  hi_o <= 1'b0;
    else if (step_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              hi_i,
  input  logic              addr_we_i,
  input  logic              cnt_we_i,
  input  logic              page_we_i,
  input  logic              xpage_we_i,
  input  logic              mode_we_i,
  input  logic              mask_we_i,
  input  logic              mask_val_i,
  input  logic              req_we_i,
  input  logic              req_val_i,
  input  logic              tc_i,
  input  logic              tc_clr_i,
  input  logic              mclr_i,
  output logic [REG_W-1:0]  addr_o,
  output logic [REG_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] page_o,
  output logic [BYTE_W-1:0] xpage_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mask_o,
  output logic              req_o,
  output logic              tc_o
);
  // address, count and pages survive master clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      cnt_o   <= '0;
      page_o  <= '0;
      xpage_o <= '0;
    end else begin
      if (addr_we_i)  addr_o  <= put_byte(addr_o, hi_i, wdata_i);
      if (cnt_we_i)   cnt_o   <= put_byte(cnt_o, hi_i, wdata_i);
      if (page_we_i)  page_o  <= wdata_i;
      if (xpage_we_i) xpage_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      mask_o <= 1'b1;
      req_o  <= 1'b0;
      tc_o   <= 1'b0;
    end else if (mclr_i) begin
      mode_o <= '0;
      mask_o <= 1'b1;
      req_o  <= 1'b0;
      tc_o   <= 1'b0;
    end else begin
      if (mode_we_i) mode_o <= wdata_i[BYTE_W-1:CH_W];
      if (mask_we_i) mask_o <= mask_val_i;
      if (req_we_i)  req_o  <= req_val_i;
      // a pulse in the clearing cycle wins
      tc_o <= tc_i | (tc_o & ~tc_clr_i);
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [OFS_W-1:0]         addr_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]        tc_i,
  output logic [BYTE_W-1:0]        cmd_o,
  output logic [NUM_CH-1:0]        req_o,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [NUM_CH-1:0]        tc_o,
  output logic [NUM_CH*REG_W-1:0]  ch_addr_o,
  output logic [NUM_CH*REG_W-1:0]  ch_count_o,
  output logic [NUM_CH*REG_W-1:0]  ch_page_o,
  output logic [NUM_CH*MODE_W-1:0] ch_mode_o
);
  localparam int HALF = BYTE_W / 2;

  port_hit_t       hit;
  logic [CH_W-1:0] sel;
  logic            ptr_hi, bp_step, bp_clr, mclr, tc_clr;

  logic [REG_W-1:0]  addr_q  [NUM_CH];
  logic [REG_W-1:0]  cnt_q   [NUM_CH];
  logic [BYTE_W-1:0] page_q  [NUM_CH];
  logic [BYTE_W-1:0] xpage_q [NUM_CH];

  dma_port_decode u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign sel     = wdata_i[CH_W-1:0];
  assign mclr    = wr_i & hit.mclr;
  assign bp_clr  = (wr_i & hit.clrptr) | mclr;
  assign bp_step = (wr_i | rd_i) & ((|hit.addr) | (|hit.cnt));
  assign tc_clr  = rd_i & hit.cmd;

  dma_byte_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bp_clr),
    .step_i (bp_step),
    .hi_o   (ptr_hi)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [CH_W-1:0] K = CH_W'(k);
    logic m_we, m_val, r_we;

    assign m_we  = wr_i & ((hit.smask & (sel == K)) | hit.clrmask | hit.wrmask);
    assign m_val = hit.smask ? wdata_i[2] : (hit.wrmask & wdata_i[k]);
    assign r_we  = wr_i & hit.req & (sel == K);

    dma_chan_regs u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wdata_i    (wdata_i),
      .hi_i       (ptr_hi),
      .addr_we_i  (wr_i & hit.addr[k]),
      .cnt_we_i   (wr_i & hit.cnt[k]),
      .page_we_i  (wr_i & hit.page[k]),
      .xpage_we_i (wr_i & hit.xpage[k]),
      .mode_we_i  (wr_i & hit.mode & (sel == K)),
      .mask_we_i  (m_we),
      .mask_val_i (m_val),
      .req_we_i   (r_we),
      .req_val_i  (wdata_i[2]),
      .tc_i       (tc_i[k]),
      .tc_clr_i   (tc_clr),
      .mclr_i     (mclr),
      .addr_o     (addr_q[k]),
      .cnt_o      (cnt_q[k]),
      .page_o     (page_q[k]),
      .xpage_o    (xpage_q[k]),
      .mode_o     (ch_mode_o[k*MODE_W +: MODE_W]),
      .mask_o     (mask_o[k]),
      .req_o      (req_o[k]),
      .tc_o       (tc_o[k])
    );

    assign ch_addr_o[k*REG_W +: REG_W]  = addr_q[k];
    assign ch_count_o[k*REG_W +: REG_W] = cnt_q[k];
    assign ch_page_o[k*REG_W +: REG_W]  = {xpage_q[k], page_q[k]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cmd_o <= '0;
    else if (mclr)              cmd_o <= '0;
    else if (wr_i && hit.cmd)   cmd_o <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (hit.addr[k])  rdata_o = get_byte(addr_q[k], ptr_hi);
        if (hit.cnt[k])   rdata_o = get_byte(cnt_q[k], ptr_hi);
        if (hit.page[k])  rdata_o = page_q[k];
        if (hit.xpage[k]) rdata_o = xpage_q[k];
      end
      if (hit.cmd)    rdata_o = {req_o, tc_o};
      if (hit.req)    rdata_o = {{HALF{1'b0}}, req_o};
      if (hit.wrmask) rdata_o = {{HALF{1'b0}}, mask_o};
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_regfile_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [OFS_W-1:0]         addr_i,
  input logic                     wr_i,
  input logic                     rd_i,
  input logic [BYTE_W-1:0]        wdata_i,
  input logic [NUM_CH-1:0]        tc_i,
  input logic [BYTE_W-1:0]        cmd_o,
  input logic [NUM_CH-1:0]        req_o,
  input logic [NUM_CH-1:0]        mask_o,
  input logic [NUM_CH-1:0]        tc_o,
  input logic [NUM_CH*MODE_W-1:0] ch_mode_o
);
  p_smask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_SMASK) |=> mask_o[$past(wdata_i[1:0])] == $past(wdata_i[2]));

  p_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_MODE) |=>
      ch_mode_o[$past(wdata_i[1:0])*MODE_W +: MODE_W] == $past(wdata_i[7:2]));

  p_tc_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i != '0 && !(wr_i && addr_i == OFS_MCLR)) |=> (tc_o & $past(tc_i)) == $past(tc_i));

  p_tc_rdclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_CMD && tc_i == '0) |=> tc_o == '0);

  p_mclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_MCLR) |=>
      (mask_o == '1 && tc_o == '0 && req_o == '0 && cmd_o == '0 && ch_mode_o == '0));

  p_clrmask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CLRMASK) |=> mask_o == '0);

  p_wrmask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_WRMASK) |=> mask_o == $past(wdata_i[3:0]));

  p_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_REQ) |=> req_o[$past(wdata_i[1:0])] == $past(wdata_i[2]));

  p_cmd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CMD) |=> cmd_o == $past(wdata_i));
endmodule

bind dma_regfile dma_regfile_chk u_chk (.*);

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A0 = 5'h00, A1 = 5'h01, A2 = 5'h02, A3 = 5'h03;
  localparam logic [4:0] C1 = 5'h05, C3 = 5'h07, P2 = 5'h0A, X2 = 5'h0E;
  localparam logic [4:0] CMD = 5'h10, REQ = 5'h11, SMSK = 5'h12, MODE = 5'h13;
  localparam logic [4:0] CBP = 5'h14, MCLR = 5'h15, CMSK = 5'h16, WAM = 5'h17;
  localparam logic [4:0] UNM = 5'h1F;

  typedef struct packed {
    logic       rd;
    logic [4:0] ofs;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VECS [NV] = '{
    '{1'b1, WAM,  8'h0F, 4'd1},   // R1 reset mask
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b0, A2,   8'h34, 4'd2},
    '{1'b0, A2,   8'h12, 4'd2},
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b1, A2,   8'h34, 4'd2},   // R2 low then high
    '{1'b1, A2,   8'h12, 4'd2},
    '{1'b0, C1,   8'hFF, 4'd2},
    '{1'b0, C1,   8'h01, 4'd2},
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b1, C1,   8'hFF, 4'd2},
    '{1'b1, C1,   8'h01, 4'd2},
    '{1'b0, A0,   8'hAA, 4'd3},
    '{1'b0, CBP,  8'h00, 4'd3},   // R3 restart mid-pair
    '{1'b0, A0,   8'h55, 4'd3},
    '{1'b0, A0,   8'h66, 4'd3},
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b1, A0,   8'h55, 4'd3},
    '{1'b1, A0,   8'h66, 4'd3},
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b0, A1,   8'h11, 4'd2},   // R2 pointer shared across ports
    '{1'b0, C3,   8'h22, 4'd2},
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b1, C3,   8'h00, 4'd2},
    '{1'b1, C3,   8'h22, 4'd2},
    '{1'b0, CMSK, 8'h00, 4'd8},   // R8
    '{1'b1, WAM,  8'h00, 4'd8},
    '{1'b0, SMSK, 8'h06, 4'd4},   // R4
    '{1'b1, WAM,  8'h04, 4'd4},
    '{1'b0, SMSK, 8'h02, 4'd4},
    '{1'b1, WAM,  8'h00, 4'd4},
    '{1'b0, WAM,  8'h0A, 4'd9},   // R9
    '{1'b1, WAM,  8'h0A, 4'd9},
    '{1'b0, P2,   8'h9C, 4'd10},  // R10
    '{1'b0, X2,   8'h01, 4'd10},
    '{1'b1, P2,   8'h9C, 4'd10},
    '{1'b1, X2,   8'h01, 4'd10},
    '{1'b0, REQ,  8'h07, 4'd11},  // R11
    '{1'b1, CMD,  8'h80, 4'd11},
    '{1'b1, REQ,  8'h08, 4'd11},
    '{1'b0, REQ,  8'h03, 4'd11},
    '{1'b1, CMD,  8'h00, 4'd11},
    '{1'b0, UNM,  8'hFF, 4'd13},  // R13
    '{1'b1, UNM,  8'h00, 4'd13},
    '{1'b1, WAM,  8'h0A, 4'd13},
    '{1'b0, CBP,  8'h00, 4'd3},
    '{1'b0, A3,   8'h01, 4'd7},   // pointer high before R7
    '{1'b0, MCLR, 8'h00, 4'd7},
    '{1'b1, WAM,  8'h0F, 4'd7},
    '{1'b1, A3,   8'h01, 4'd7},   // R7 pointer back to low
    '{1'b0, CBP,  8'h00, 4'd7},
    '{1'b1, A2,   8'h34, 4'd7},   // R7 address kept
    '{1'b1, A2,   8'h12, 4'd7}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [3:0] tc_i = '0;
  logic [7:0] rdata_o, cmd_o;
  logic [3:0] req_o, mask_o, tc_o;
  logic [63:0] ch_addr_o, ch_count_o, ch_page_o;
  logic [23:0] ch_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dma_regfile uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .tc_i       (tc_i),
    .cmd_o      (cmd_o),
    .req_o      (req_o),
    .mask_o     (mask_o),
    .tc_o       (tc_o),
    .ch_addr_o  (ch_addr_o),
    .ch_count_o (ch_count_o),
    .ch_page_o  (ch_page_o),
    .ch_mode_o  (ch_mode_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state at ports
    check("R1 mask", {60'd0, mask_o}, 64'hF);
    check("R1 tc/req/cmd", {52'd0, tc_o, req_o, cmd_o}, 64'd0);
    check("R1 addr/mode", ch_addr_o | ch_count_o | ch_page_o | {40'd0, ch_mode_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        bus_rd(VECS[i].ofs, rv);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), {56'd0, rv}, {56'd0, VECS[i].data});
      end else begin
        bus_wr(VECS[i].ofs, VECS[i].data);
      end
    end

    // R2 and R10 at the outputs
    check("R2 ch2 addr", {48'd0, ch_addr_o[32 +: 16]}, 64'h1234);
    check("R2 ch1 count", {48'd0, ch_count_o[16 +: 16]}, 64'h01FF);
    check("R10 ch2 page", {48'd0, ch_page_o[32 +: 16]}, 64'h019C);

    // R12 command byte
    bus_wr(CMD, 8'hA5);
    check("R12 cmd", {56'd0, cmd_o}, 64'hA5);

    // R5 modes: device-to-memory on ch1, memory-to-device on ch2
    bus_wr(MODE, 8'h45);
    bus_wr(MODE, 8'h4A);
    check("R5 ch1 mode", {58'd0, ch_mode_o[6 +: 6]}, 64'h11);
    check("R5 ch2 mode", {58'd0, ch_mode_o[12 +: 6]}, 64'h12);
    check("R5 ch0 mode", {58'd0, ch_mode_o[0 +: 6]}, 64'h00);

    // R6 terminal count set, read, clear
    @(negedge clk_i); tc_i = 4'b0101;
    @(negedge clk_i); tc_i = 4'b0000;
    check("R6 tc set", {60'd0, tc_o}, 64'h5);
    bus_rd(CMD, rv);
    check("R6 status", {56'd0, rv}, 64'h05);
    check("R6 tc cleared", {60'd0, tc_o}, 64'h0);
    // pulse in the same cycle as the status read
    @(negedge clk_i);
    addr_i = CMD; rd_i = 1'b1; tc_i = 4'b0010;
    #1 rv = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0; tc_i = 4'b0000;
    check("R6 same-cycle read", {56'd0, rv}, 64'h00);
    check("R6 same-cycle kept", {60'd0, tc_o}, 64'h2);

    // R7 master clear wipes mode, tc, cmd
    bus_wr(MCLR, 8'h5A);
    check("R7 mode", {40'd0, ch_mode_o}, 64'd0);
    check("R7 tc/cmd", {52'd0, tc_o, cmd_o}, 64'd0);
    check("R7 addr kept", {48'd0, ch_addr_o[32 +: 16]}, 64'h1234);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule